// File: doc/BRIEF.md
# Video Dither Sequence Generator

This block adds a small pseudo-random offset to each sample of an 8-bit video stream. The result is clamped so that it never wraps. A free-running 16-bit linear feedback shift register supplies the random sequence. A two-bit mode field sets how often the sequence moves forward: on every pixel clock, once per line on the rising edge of the horizontal sync, or once per frame on the rising edge of the vertical sync.

One bit selects the dither span. The wide setting spreads the offset over four codes, from −2 to +1. The narrow setting spreads it over two codes, −1 or 0. Dither is off after reset. While it is off, samples pass through unchanged and the reported dither value is zero. A seed-clear control reloads the fixed seed while it is held high. The sequence starts again from the seed when the control is released.

The dithered sample appears one pixel clock after the input sample. The current dither value is brought out alongside it so that downstream logic can monitor it.

Top module: `video_dither_gen`

## Requirements
- R1: After reset, `pix_out` is 0. The shift register holds the seed 16'hACE1, and `dith_val` is 0 while `dith_en` is 0.
- R2: While `dith_en` is 0, `dith_val` is 0 and `pix_out` equals the `pix_in` value of the previous clock.
- R3: The shift register moves left on each step. The new bit 0 is the XOR of bits 15, 13, 12 and 10, which gives the maximal polynomial x^16+x^14+x^13+x^11+1. The register never holds zero.
- R4: With `amp_sel` = 0 and dither enabled, `dith_val` is register bits [1:0] read as a two's-complement number, giving a range of −2..+1.
- R5: With `amp_sel` = 1 and dither enabled, `dith_val` is −1 when register bit 0 is 1 and 0 when it is 0.
- R6: With `step_mode` = 00, the register steps on every clock.
- R7: With `step_mode` = 01, the register steps only in a clock where `hsync` is 1 and was 0 in the previous clock. At all other times it holds.
- R8: With `step_mode` = 10 or 11, the register steps only on a rising edge of `vsync`, detected the same way as in R7. Edges of `hsync` have no effect in these modes.
- R9: While `seed_clr` is 1, the register is loaded with the seed on every clock and does not step. Stepping resumes on the first clock after `seed_clr` returns to 0.
- R10: When dither is enabled, `pix_out` equals the previous clock's `pix_in` plus `dith_val`, clamped to the range 0..255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| pix_in | input | 8 | Incoming video sample |
| dith_en | input | 1 | Dither enable |
| amp_sel | input | 1 | Span select: 0 for four codes, 1 for two codes |
| step_mode | input | 2 | Sequence advance: 00 per pixel, 01 per line, 1x per frame |
| seed_clr | input | 1 | Reload the seed while high |
| pix_out | output | 8 | Dithered, clamped sample, delayed one clock |
| dith_val | output | 3 | Current signed dither value |

## Verification
The hardest cases to reach are the clamp boundaries. A sample of 0 must meet a negative offset, and a sample of 255 must meet a +1 offset. The random sequence decides when either happens, so the bench holds the extreme codes for long stretches of per-pixel stepping until both saturations have been forced many times. The held modes also need care. Pulses are sent on the sync input that should be ignored, as well as on the one that should step the sequence. Mid-run seed clears confirm that the sequence restarts exactly from the seed. A behavioural shift-register model, written in integers, checks every clock.

// File: rtl/video_dither_gen.sv
module video_dither_gen #(
  parameter int          W    = 8,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hsync,
  input  logic                vsync,
  input  logic [W-1:0]        pix_in,
  input  logic                dith_en,
  input  logic                amp_sel,
  input  logic [1:0]          step_mode,
  input  logic                seed_clr,
  output logic [W-1:0]        pix_out,
  output logic signed [2:0]   dith_val
);

  localparam int SW = W + 2;

  logic [15:0]       lfsr;
  logic              hs_q, vs_q;
  logic              step;
  logic signed [2:0] raw;
  logic [SW-1:0]     sum;
  logic [W-1:0]      clamped;

  wire hs_rise = hsync & ~hs_q;
  wire vs_rise = vsync & ~vs_q;
  wire fb      = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_comb begin
    case (step_mode)
      2'b00:   step = 1'b1;
      2'b01:   step = hs_rise;
      default: step = vs_rise;
    endcase
  end

  assign raw      = amp_sel ? (lfsr[0] ? 3'sb111 : 3'sb000) : {lfsr[1], lfsr[1:0]};
  assign dith_val = dith_en ? raw : 3'sb000;
  assign sum      = {2'b00, pix_in} + {{(SW-3){dith_val[2]}}, dith_val};
  assign clamped  = sum[SW-1] ? '0 : (sum[W] ? '1 : sum[W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr    <= SEED;
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      pix_out <= '0;
    end else begin
      hs_q    <= hsync;
      vs_q    <= vsync;
      pix_out <= dith_en ? clamped : pix_in;
      if (seed_clr)  lfsr <= SEED;
      else if (step) lfsr <= {lfsr[14:0], fb};
    end
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0000);  // R3

  AST_SEED_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    seed_clr |=> lfsr == SEED);  // R9

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_mode == 2'b01 && !(hsync && !hs_q) && !seed_clr) |=> $stable(lfsr));  // R7

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_mode[1] && !(vsync && !vs_q) && !seed_clr) |=> $stable(lfsr));  // R8

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !dith_en |=> pix_out == $past(pix_in));  // R2

  AST_NARROW_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (dith_en && amp_sel) |-> dith_val <= 3'sb000);  // R5

endmodule

// File: tb/video_dither_gen_test.sv
`timescale 1ns/1ps
module video_dither_gen_test;
  logic clk = 0, rst_n = 0, hsync = 0, vsync = 0;
  logic [7:0] pix_in = 0;
  logic dith_en = 0, amp_sel = 0, seed_clr = 0;
  logic [1:0] step_mode = 0;
  logic [7:0] pix_out;
  logic signed [2:0] dith_val;

  int errors = 0, checks = 0;
  int m_lf, m_pix, m_hs, m_vs;
  int lo_hits = 0, hi_hits = 0;
  bit done = 0;

  video_dither_gen uut (.clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .pix_in(pix_in), .dith_en(dith_en), .amp_sel(amp_sel), .step_mode(step_mode),
    .seed_clr(seed_clr), .pix_out(pix_out), .dith_val(dith_val));

  always #10 clk = ~clk;

  function automatic int exp_dith();
    if (!dith_en) return 0;
    if (amp_sel)  return (m_lf & 1) ? -1 : 0;
    return ((m_lf & 3) >= 2) ? (m_lf & 3) - 4 : (m_lf & 3);
  endfunction

  function automatic int lf_next(int v);
    int b = ((v >> 15) ^ (v >> 13) ^ (v >> 12) ^ (v >> 10)) & 1;
    return ((v << 1) | b) & 16'hFFFF;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lf = 16'hACE1; m_pix = 0; m_hs = 0; m_vs = 0;
    end else begin
      int s, adv;
      s = pix_in + exp_dith();
      if (dith_en) begin
        if (s < 0) lo_hits++;
        if (s > 255) hi_hits++;
      end
      m_pix = s < 0 ? 0 : (s > 255 ? 255 : s);
      if (step_mode == 0)      adv = 1;
      else if (step_mode == 1) adv = hsync && !m_hs;
      else                     adv = vsync && !m_vs;
      if (seed_clr)  m_lf = 16'hACE1;
      else if (adv)  m_lf = lf_next(m_lf);
      m_hs = hsync; m_vs = vsync;
    end
  end

  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      string rq;
      if (!dith_en) rq = "R2";
      else if (amp_sel) rq = "R5";
      else rq = "R4";
      if (step_mode == 1) rq = {rq, "/R7"};
      else if (step_mode != 0) rq = {rq, "/R8"};
      else rq = {rq, "/R6/R3"};
      chk({rq, " dith_val"}, dith_val, exp_dith());
      chk(dith_en ? "R10 pix_out" : "R2 pix_out", pix_out, m_pix);
    end
  end

  task automatic cyc(int n);
    repeat (n) begin
      @(negedge clk);
      pix_in = ($urandom % 2) ? (($urandom % 2) ? 8'd0 : 8'd255) : 8'($urandom);
    end
  endtask

  task automatic pulse(bit line, int gap);
    @(negedge clk); if (line) hsync = 1; else vsync = 1;
    cyc(2);
    @(negedge clk); if (line) hsync = 0; else vsync = 0;
    cyc(gap);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk("R1 pix_out", pix_out, 0);
    chk("R1 dith_val", dith_val, 0);
    @(negedge clk); rst_n = 1;
    cyc(40);
    dith_en = 1; amp_sel = 0; cyc(300);
    amp_sel = 1; cyc(200);
    amp_sel = 0;
    @(negedge clk); pix_in = 0;   repeat (80) @(negedge clk);
    @(negedge clk); pix_in = 255; repeat (80) @(negedge clk);
    @(negedge clk); seed_clr = 1; cyc(3);
    #5; chk("R9 seeded dith_val", dith_val, 1);
    @(negedge clk); seed_clr = 0; cyc(30);
    step_mode = 2'b01;
    for (int i = 0; i < 6; i++) begin pulse(1, 7); pulse(0, 5); end
    step_mode = 2'b10;
    for (int i = 0; i < 5; i++) begin pulse(0, 6); pulse(1, 4); end
    step_mode = 2'b11; amp_sel = 1;
    for (int i = 0; i < 5; i++) begin pulse(0, 3); pulse(1, 3); end
    @(negedge clk); seed_clr = 1; cyc(2);
    @(negedge clk); seed_clr = 0; pulse(0, 4);
    step_mode = 2'b00; dith_en = 0; cyc(40);
    checks++;
    if (lo_hits == 0 || hi_hits == 0) begin
      errors++;
      $display("FAIL R10 clamp coverage actual=%0d/%0d expected=nonzero", lo_hits, hi_hits);
    end
    done = 1;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule